// File: doc/BRIEF.md
# Four-Channel Shadowed Pulse-Width Modulator

This block produces four independent pulse-width-modulated outputs from a shared 1 MHz tick enable (`tick_en`). Each channel keeps an active configuration: a period length, a high-time length and a control word. The control word has a prescale select, which makes the channel count once every 1, 2, 4 or 8 ticks, and an inversion bit. A host programs a channel over a single-cycle register bus. It writes the control word first, then the high time, then the period. Control and high-time writes go only into shadow storage. The period write is the commit: it stores the period in the shadow and arms the channel.

A running channel never takes a new setting partway through a period. It finishes the period in progress and then moves every shadowed value into the active set in the same clock. A committed period of zero is handled the same way: the running period completes, and from then on the output stays low. An idle channel that receives a nonzero period starts at once. Register reads return the active values, so a read shows the configuration that is in effect.

Each channel is a three-state machine. The states are `CH_IDLE` (stopped, output low), `CH_RUN` (counting, nothing pending) and `CH_ARMED` (counting, commit pending). The transitions are:
- *start*: `CH_IDLE` to `CH_RUN`, on a nonzero period write.
- *arm*: `CH_RUN` to `CH_ARMED`, on any period write.
- *swap*: `CH_ARMED` to `CH_RUN`, at the end of the period, when the new period is nonzero.
- *stop*: `CH_ARMED` to `CH_IDLE`, at the end of the period, when the new period is zero.

A period write that lands in the same clock as a period end in `CH_RUN` only arms the channel. The swap then happens at the next period end.

Top module: `pwm_quad_shadow`

## Requirements
- R1: After a synchronous active-low reset, all outputs are low, every channel is idle, and every register reads zero.
- R2: The period register of channel c is at byte address 0x400+4c, the high-time register at 0x420+4c and the control register at 0x440+4c. Only addresses with bits [1:0] equal to zero respond. Control bits [1:0] hold the prescale select s and bit 5 holds the inversion flag. A read returns the active value, with all unused bits zero.
- R3: A running channel advances its in-period count once every 2^s pulses of `tick_en`.
- R4: With the inversion flag clear, a running channel with period P and high time D is high while its count (0 to P-1) is below D, and low otherwise. When D >= P the output is high all the time.
- R5: With the inversion flag set, a running channel drives the complement of the R4 level.
- R6: An idle channel that receives a nonzero period write loads all of its shadow values in that clock. Its count is 0 in the following cycle. A period write of zero leaves an idle channel idle and low.
- R7: Control and high-time writes that are not followed by a period write change neither the output nor the read-back values.
- R8: A period write to a running channel keeps the old settings until the running period ends. All new values then apply together, and the count restarts at 0.
- R9: A zero period written to a running channel lets the running period complete. The output is then low regardless of the inversion flag, and the period reads zero.
- R10: While `tick_en` is low and no write occurs, no output changes.
- R11: The channels run independently: programming one channel does not disturb another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 1 MHz base tick, one clock wide |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W (12) | Byte address for writes and reads |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Active value at `bus_addr` (combinational) |
| pwm_out | output | NCH (4) | One modulated output per channel |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters and a 2-bit prescale select. `tick_en` is held high for most of the run, so one base tick equals one clock. This makes the slowest prescale setting short enough to sweep completely. Every combination of prescale, inversion, period 1 to 6 and high time 0 to 7 is applied and compared against an arithmetic waveform model over two full periods. That covers the zero-high-time and full-high-time corners. Directed sequences cover the points the sweep cannot reach: a commit that waits for a period end, a stop, shadow-only writes, a gapped `tick_en`, and two channels running at once.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

    // per-channel sequencing state
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_ARMED = 2'd2
    } ch_state_e;

    // register map: bits above REGION_LSB pick the register kind,
    // the word slot below it picks the channel
    localparam int         REGION_LSB   = 5;
    localparam int         SLOT_W       = 3;
    localparam logic [6:0] RGN_PERIOD   = 7'h20;
    localparam logic [6:0] RGN_DUTY     = 7'h21;
    localparam logic [6:0] RGN_CTRL     = 7'h22;
    localparam int         CTRL_POL_BIT = 5;

endpackage

// File: rtl/pwmq_prescaler.sv
module pwmq_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             ptick
);
    // widest divider is 2**(2**SEL_W - 1)
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] pre_cnt;
    logic [DIV_W-1:0] wrap_at;

    always_comb begin
        wrap_at = DIV_W'((1 << sel) - 1);
        ptick   = run && tick_en && (pre_cnt == wrap_at);
    end

    // restarts from zero whenever the channel is stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
        end else if (tick_en) begin
            pre_cnt <= (pre_cnt == wrap_at) ? '0 : pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwmq_shadow.sv
module pwmq_shadow #(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_duty,
    input  logic             wr_period,
    input  logic [CNT_W-1:0] wdata_cnt,
    input  logic [SEL_W-1:0] wdata_sel,
    input  logic             wdata_pol,
    output logic [CNT_W-1:0] sh_period,
    output logic [CNT_W-1:0] sh_duty,
    output logic [SEL_W-1:0] sh_sel,
    output logic             sh_pol
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_period <= '0;
            sh_duty   <= '0;
            sh_sel    <= '0;
            sh_pol    <= 1'b0;
        end else begin
            if (wr_period) sh_period <= wdata_cnt;
            if (wr_duty)   sh_duty   <= wdata_cnt;
            if (wr_ctrl) begin
                sh_sel <= wdata_sel;
                sh_pol <= wdata_pol;
            end
        end
    end

endmodule

// File: rtl/pwmq_channel.sv
module pwmq_channel
    import pwmq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_period,
    input  logic [CNT_W-1:0] sh_period,
    input  logic [CNT_W-1:0] sh_duty,
    input  logic [SEL_W-1:0] sh_sel,
    input  logic             sh_pol,
    output logic [CNT_W-1:0] act_period,
    output logic [CNT_W-1:0] act_duty,
    output logic [SEL_W-1:0] act_sel,
    output logic             act_pol,
    output logic             running,
    output logic             pwm_o
);

    ch_state_e        state_q;
    ch_state_e        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] next_period;
    logic             ptick;
    logic             at_end;
    logic             load_now;

    assign running = (state_q != CH_IDLE);

    pwmq_prescaler #(
        .SEL_W (SEL_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (running),
        .sel     (act_sel),
        .ptick   (ptick)
    );

    // a commit in the very cycle of a swap supplies the newest period
    always_comb begin
        next_period = commit ? commit_period : sh_period;
        at_end      = ptick && (cnt_q >= act_period - 1'b1);
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (commit && (commit_period != '0)) state_d = CH_RUN;   // start
            end
            CH_RUN: begin
                if (commit) state_d = CH_ARMED;                           // arm
            end
            CH_ARMED: begin
                if (at_end) begin
                    state_d = (next_period == '0) ? CH_IDLE : CH_RUN;    // stop / swap
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_comb begin
        load_now = ((state_q == CH_IDLE) && commit && (commit_period != '0))
                || ((state_q == CH_ARMED) && at_end);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // active configuration and in-period counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= '0;
            act_duty   <= '0;
            act_sel    <= '0;
            act_pol    <= 1'b0;
            cnt_q      <= '0;
        end else if (load_now) begin
            act_period <= next_period;
            act_duty   <= sh_duty;
            act_sel    <= sh_sel;
            act_pol    <= sh_pol;
            cnt_q      <= '0;
        end else if (ptick) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    // output level per state
    always_comb begin
        unique case (state_q)
            CH_IDLE:          pwm_o = 1'b0;
            CH_RUN, CH_ARMED: pwm_o = (cnt_q < act_duty) ^ act_pol;
            default:          pwm_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwmq_regif.sv
module pwmq_regif
    import pwmq_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic [NCH-1:0][CNT_W-1:0]  act_period,
    input  logic [NCH-1:0][CNT_W-1:0]  act_duty,
    input  logic [NCH-1:0][SEL_W-1:0]  act_sel,
    input  logic [NCH-1:0]             act_pol,
    output logic [NCH-1:0]             wr_period,
    output logic [NCH-1:0]             wr_duty,
    output logic [NCH-1:0]             wr_ctrl,
    output logic [CNT_W-1:0]           wdata_cnt,
    output logic [SEL_W-1:0]           wdata_sel,
    output logic                       wdata_pol,
    output logic [DATA_W-1:0]          bus_rdata
);
    localparam int RGN_W = ADDR_W - REGION_LSB;

    logic [RGN_W-1:0]  rgn;
    logic [SLOT_W-1:0] slot;
    logic              aligned;
    logic              hit_per;
    logic              hit_duty;
    logic              hit_ctrl;
    logic              wdata_unused;

    assign rgn          = bus_addr[ADDR_W-1:REGION_LSB];
    assign slot         = bus_addr[REGION_LSB-1:2];
    assign aligned      = (bus_addr[1:0] == 2'b00);
    assign hit_per      = aligned && (rgn == RGN_W'(RGN_PERIOD));
    assign hit_duty     = aligned && (rgn == RGN_W'(RGN_DUTY));
    assign hit_ctrl     = aligned && (rgn == RGN_W'(RGN_CTRL));
    assign wdata_cnt    = bus_wdata[CNT_W-1:0];
    assign wdata_sel    = bus_wdata[SEL_W-1:0];
    assign wdata_pol    = bus_wdata[CTRL_POL_BIT];
    assign wdata_unused = ^bus_wdata[DATA_W-1:CNT_W];

    // write strobes, one per channel and register kind
    always_comb begin
        wr_period = '0;
        wr_duty   = '0;
        wr_ctrl   = '0;
        for (int k = 0; k < NCH; k++) begin
            if (bus_wr && (slot == SLOT_W'(k))) begin
                wr_period[k] = hit_per;
                wr_duty[k]   = hit_duty;
                wr_ctrl[k]   = hit_ctrl;
            end
        end
    end

    // read mux over the active set
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NCH; k++) begin
            if (slot == SLOT_W'(k)) begin
                if (hit_per)  bus_rdata = DATA_W'(act_period[k]);
                if (hit_duty) bus_rdata = DATA_W'(act_duty[k]);
                if (hit_ctrl) bus_rdata = DATA_W'(act_sel[k])
                                        | (DATA_W'(act_pol[k]) << CTRL_POL_BIT);
            end
        end
    end

endmodule

// File: rtl/pwm_quad_shadow.sv
module pwm_quad_shadow #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int SEL_W  = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    logic [NCH-1:0][CNT_W-1:0] act_period;
    logic [NCH-1:0][CNT_W-1:0] act_duty;
    logic [NCH-1:0][SEL_W-1:0] act_sel;
    logic [NCH-1:0]            act_pol;
    logic [NCH-1:0]            wr_period;
    logic [NCH-1:0]            wr_duty;
    logic [NCH-1:0]            wr_ctrl;
    logic [NCH-1:0]            run_vec;
    logic [CNT_W-1:0]          wdata_cnt;
    logic [SEL_W-1:0]          wdata_sel;
    logic                      wdata_pol;

    pwmq_regif #(
        .NCH    (NCH),
        .CNT_W  (CNT_W),
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regif (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .act_period (act_period),
        .act_duty   (act_duty),
        .act_sel    (act_sel),
        .act_pol    (act_pol),
        .wr_period  (wr_period),
        .wr_duty    (wr_duty),
        .wr_ctrl    (wr_ctrl),
        .wdata_cnt  (wdata_cnt),
        .wdata_sel  (wdata_sel),
        .wdata_pol  (wdata_pol),
        .bus_rdata  (bus_rdata)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [CNT_W-1:0] sh_period;
        logic [CNT_W-1:0] sh_duty;
        logic [SEL_W-1:0] sh_sel;
        logic             sh_pol;

        pwmq_shadow #(
            .CNT_W (CNT_W),
            .SEL_W (SEL_W)
        ) u_shadow (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctrl   (wr_ctrl[i]),
            .wr_duty   (wr_duty[i]),
            .wr_period (wr_period[i]),
            .wdata_cnt (wdata_cnt),
            .wdata_sel (wdata_sel),
            .wdata_pol (wdata_pol),
            .sh_period (sh_period),
            .sh_duty   (sh_duty),
            .sh_sel    (sh_sel),
            .sh_pol    (sh_pol)
        );

        pwmq_channel #(
            .CNT_W (CNT_W),
            .SEL_W (SEL_W)
        ) u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .tick_en       (tick_en),
            .commit        (wr_period[i]),
            .commit_period (wdata_cnt),
            .sh_period     (sh_period),
            .sh_duty       (sh_duty),
            .sh_sel        (sh_sel),
            .sh_pol        (sh_pol),
            .act_period    (act_period[i]),
            .act_duty      (act_duty[i]),
            .act_sel       (act_sel[i]),
            .act_pol       (act_pol[i]),
            .running       (run_vec[i]),
            .pwm_o         (pwm_out[i])
        );
    end

endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_en,
    input logic           bus_wr,
    input logic [NCH-1:0] pwm_out,
    input logic [NCH-1:0] run_vec
);

    AST_RESET_OUT_LOW: assert property (@(posedge clk)
        !rst_n |=> (pwm_out == '0));                                           // R1

    AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !bus_wr) |=> $stable(pwm_out));                           // R10

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_START_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_vec[g]) |-> $past(bus_wr));                              // R6

        AST_STOP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(run_vec[g]) |-> $past(tick_en));                             // R9

        AST_IDLE_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !run_vec[g] |-> !pwm_out[g]);                                      // R9
    end

endmodule

bind pwm_quad_shadow pwmq_checker #(.NCH(NCH)) u_pwmq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .bus_wr  (bus_wr),
    .pwm_out (pwm_out),
    .run_vec (run_vec)
);

// File: tb/test_pwm_quad_shadow.sv
module test_pwm_quad_shadow;

    localparam int NCH    = 4;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NCH-1:0]    pwm_out;

    int  nvec = 0;
    int  nfail = 0;
    int  tks = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) if (tick_en) tks <= tks + 1;

    pwm_quad_shadow i_pwm_quad_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [ADDR_W-1:0] a_per(int ch);  return ADDR_W'(12'h400 + 4*ch); endfunction
    function automatic logic [ADDR_W-1:0] a_duty(int ch); return ADDR_W'(12'h420 + 4*ch); endfunction
    function automatic logic [ADDR_W-1:0] a_ctrl(int ch); return ADDR_W'(12'h440 + 4*ch); endfunction

    // reference level: count = (ticks >> sel) mod P, high while below D
    function automatic int exp_lvl(int j, int p, int d, int s, int pol);
        int c;
        c = (j >> s) % p;
        return ((c < d) ? 1 : 0) ^ pol;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_wr = 1'b0;
        tick_en = 1'b1;
        repeat (2) step();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input int v);
        bus_addr  = a;
        bus_wdata = DATA_W'(v);
        bus_wr    = 1'b1;
        step();
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int v;
        int t0;
        int t1;
        int tb;
        int fin;
        step();
        do_reset();

        // R1: reset state
        chk(pwm_out == '0, "R1", pwm_out, 0);
        for (int ch = 0; ch < NCH; ch++) begin
            rd(a_per(ch), v);  chk(v == 0, "R1", v, 0);
            rd(a_duty(ch), v); chk(v == 0, "R1", v, 0);
            rd(a_ctrl(ch), v); chk(v == 0, "R1", v, 0);
        end

        // R6: zero period on an idle channel keeps it idle and low
        wr(a_ctrl(3), 32'h20);
        wr(a_per(3), 0);
        for (int k = 0; k < 10; k++) begin
            chk(pwm_out == '0, "R6", pwm_out, 0);
            step();
        end
        rd(a_per(3), v); chk(v == 0, "R6", v, 0);

        // R2: misaligned address does not respond
        wr(12'h401, 5);
        rd(a_per(0), v); chk(v == 0, "R2", v, 0);
        chk(pwm_out == '0, "R2", pwm_out, 0);

        // Sweep: R3 R4 R5 R6 R11 across all prescale/polarity/period/duty
        for (int s = 0; s < 4; s++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int p = 1; p <= 6; p++) begin
                    for (int d = 0; d < 8; d++) begin
                        int ch;
                        ch = (p + d + s) % NCH;
                        do_reset();
                        wr(a_ctrl(ch), s | (pol << 5));
                        wr(a_duty(ch), d);
                        wr(a_per(ch), p);
                        t0 = tks;
                        rd(a_per(ch), v);  chk(v == p, "R2", v, p);
                        rd(a_duty(ch), v); chk(v == d, "R2", v, d);
                        rd(a_ctrl(ch), v); chk(v == (s | (pol << 5)), "R2", v, s | (pol << 5));
                        for (int k = 0; k < 2 * p * (1 << s); k++) begin
                            int e;
                            e = exp_lvl(tks - t0, p, d, s, pol);
                            if (k == 0)
                                chk(int'(pwm_out[ch]) == e, "R6", pwm_out[ch], e);
                            else if (pol == 0)
                                chk(int'(pwm_out[ch]) == e, "R4", pwm_out[ch], e); // count paced per R3
                            else
                                chk(int'(pwm_out[ch]) == e, "R5", pwm_out[ch], e);
                            chk((pwm_out & ~(NCH'(1) << ch)) == '0, "R11", pwm_out, 0);
                            step();
                        end
                    end
                end
            end
        end

        // R7 / R8 / R9 on channel 1
        do_reset();
        wr(a_ctrl(1), 0);
        wr(a_duty(1), 1);
        wr(a_per(1), 4);
        t0 = tks;
        wr(a_ctrl(1), 1 | (1 << 5));
        wr(a_duty(1), 3);
        for (int k = 0; k < 12; k++) begin
            int e;
            e = exp_lvl(tks - t0, 4, 1, 0, 0);
            chk(int'(pwm_out[1]) == e, "R7", pwm_out[1], e);
            rd(a_duty(1), v); chk(v == 1, "R7", v, 1);
            rd(a_ctrl(1), v); chk(v == 0, "R7", v, 0);
            step();
        end
        wr(a_per(1), 5);
        fin = 0;
        for (int k = 0; k < 20 && fin == 0; k++) begin
            int e;
            e = exp_lvl(tks - t0, 4, 1, 0, 0);
            chk(int'(pwm_out[1]) == e, "R8", pwm_out[1], e);
            rd(a_per(1), v); chk(v == 4, "R8", v, 4);
            if (((tks - t0) % 4) == 3) fin = 1;
            step();
        end
        t1 = tks;
        rd(a_per(1), v);  chk(v == 5, "R8", v, 5);
        rd(a_duty(1), v); chk(v == 3, "R8", v, 3);
        rd(a_ctrl(1), v); chk(v == 33, "R8", v, 33);
        for (int k = 0; k < 20; k++) begin
            int e;
            e = exp_lvl(tks - t1, 5, 3, 1, 1);
            chk(int'(pwm_out[1]) == e, "R8", pwm_out[1], e);
            step();
        end
        wr(a_per(1), 0);
        fin = 0;
        for (int k = 0; k < 40 && fin == 0; k++) begin
            int e;
            e = exp_lvl(tks - t1, 5, 3, 1, 1);
            chk(int'(pwm_out[1]) == e, "R9", pwm_out[1], e);
            if (((tks - t1) % 10) == 9) fin = 1;
            step();
        end
        for (int k = 0; k < 25; k++) begin
            chk(pwm_out[1] == 1'b0, "R9", pwm_out[1], 0);
            step();
        end
        rd(a_per(1), v); chk(v == 0, "R9", v, 0);

        // R10 / R3: gapped tick on channel 2, prescale 2
        do_reset();
        wr(a_ctrl(2), 1);
        wr(a_duty(2), 2);
        wr(a_per(2), 3);
        t0 = tks;
        for (int k = 0; k < 60; k++) begin
            int e;
            e = exp_lvl(tks - t0, 3, 2, 1, 0);
            chk(int'(pwm_out[2]) == e, "R3", pwm_out[2], e);
            tick_en = (k % 3) != 0;
            step();
        end
        tick_en = 1'b0;
        tb = int'(pwm_out[2]);
        for (int k = 0; k < 8; k++) begin
            step();
            chk(int'(pwm_out[2]) == tb, "R10", pwm_out[2], tb);
        end
        tick_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            int e;
            e = exp_lvl(tks - t0, 3, 2, 1, 0);
            chk(int'(pwm_out[2]) == e, "R10", pwm_out[2], e);
            step();
        end

        // R11: two channels running together
        do_reset();
        wr(a_ctrl(0), 0);
        wr(a_duty(0), 1);
        wr(a_per(0), 3);
        t0 = tks;
        wr(a_ctrl(3), 2 | (1 << 5));
        wr(a_duty(3), 4);
        wr(a_per(3), 5);
        t1 = tks;
        for (int k = 0; k < 60; k++) begin
            int e0;
            int e3;
            e0 = exp_lvl(tks - t0, 3, 1, 0, 0);
            e3 = exp_lvl(tks - t1, 5, 4, 2, 1);
            chk(int'(pwm_out[0]) == e0, "R11", pwm_out[0], e0);
            chk(int'(pwm_out[3]) == e3, "R11", pwm_out[3], e3);
            chk(pwm_out[2:1] == 2'b00, "R11", pwm_out[2:1], 0);
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule